// File: doc/BRIEF.md
# Counter Overflow Status Unit

This block keeps the sticky overflow flags for a bank of performance counters: one cycle counter, an optional instruction counter and up to 31 event counters. The counters live elsewhere. Each cycle they report an increment strobe together with two carry indications: one for a carry out of bit 31 and one for a carry out of bit 63. The unit decides from run-time mode controls whether the 32-bit wrap or the 64-bit wrap counts as an overflow. It then records the result in one 64-bit flag word.

Software sees the flag word through two write views over the same storage. The set view sets every flag written with a 1. The clear view clears every flag written with a 1. A 0 written through either view does nothing. Flags for counters that are not implemented, and all reserved positions, read as zero and cannot be written. A summary output ORs the flags selected by a per-bit enable mask, so that logic outside the block can raise an interrupt from it.

Top module: `ovf_status_unit`

## Requirements
- R1: After reset every bit of `rd_data` is 0 and `ovf_any` is 0.
- R2: The cycle counter flag is bit 31. With `cyc_long`=0 it sets when `cyc_inc` and `cyc_c32` are both 1 in a cycle. With `cyc_long`=1 it sets only when `cyc_inc` and `cyc_c64` are both 1. A carry without `cyc_inc` sets nothing.
- R3: Event counter n owns flag bit n. The event long mode is `evt_long_hyp` OR `evt_long_loc`. When that mode is 0, `evt_inc[n]` together with `evt_c32[n]` sets the flag. When it is 1, `evt_inc[n]` together with `evt_c64[n]` sets it.
- R4: Flag bits from NUM_EVT up to 30 always read 0, and set-view writes to them have no effect. With the default NUM_EVT=6, the readable mask is 64'h0000_0001_8000_003F.
- R5: When HAS_ICNT=1, bit 32 is the instruction counter flag. It follows the event long mode, using `icnt_inc`, `icnt_c32` and `icnt_c64`. When HAS_ICNT=0, bit 32 reads 0.
- R6: Bits 63:33 always read 0, and writes to them are ignored.
- R7: A flag that is set stays set until a clear-view write with a 1 in its position.
- R8: `set_we` with `wdata` sets every implemented bit that holds a 1. `clr_we` with `wdata` clears every such bit. Bits written with 0 keep their value. The update is visible on `rd_data` after the next rising edge.
- R9: A hardware overflow on a bit in the same cycle as a clear of that bit leaves the flag set.
- R10: A set and a clear of the same bit in the same cycle leave the flag set.
- R11: `ovf_any` equals the OR of `rd_data & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_inc | input | 1 | Cycle counter increment strobe |
| cyc_c32 | input | 1 | Cycle counter carry out of bit 31 |
| cyc_c64 | input | 1 | Cycle counter carry out of bit 63 |
| cyc_long | input | 1 | Cycle counter overflow at 64-bit wrap |
| icnt_inc | input | 1 | Instruction counter increment strobe |
| icnt_c32 | input | 1 | Instruction counter carry out of bit 31 |
| icnt_c64 | input | 1 | Instruction counter carry out of bit 63 |
| evt_inc | input | NUM_EVT | Event counter increment strobes |
| evt_c32 | input | NUM_EVT | Event counter carries out of bit 31 |
| evt_c64 | input | NUM_EVT | Event counter carries out of bit 63 |
| evt_long_hyp | input | 1 | Event long mode control, higher privilege |
| evt_long_loc | input | 1 | Event long mode control, local |
| set_we | input | 1 | Write strobe for the set view |
| clr_we | input | 1 | Write strobe for the clear view |
| wdata | input | 64 | Write data for either view |
| irq_en | input | 64 | Per-bit enable for the summary output |
| rd_data | output | 64 | Current flag word |
| ovf_any | output | 1 | OR of enabled flags |

## Verification
A counter wrap can arrive in the same cycle that software clears or sets the same flag. The precedence of these sources is what most easily goes wrong. The bench creates the collision deliberately. It first sets a flag, then asserts the overflow inputs and a clear of that bit together. It judges the result on `rd_data` one edge later, where the flag must still be 1. Set and clear written together are judged the same way. Random traffic repeats such collisions across many bits, and a bench model computes every resulting flag word for comparison.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int unsigned FLAG_W   = 64;
  localparam int unsigned MAX_EVT  = 31;
  localparam int unsigned CYC_BIT  = 31;
  localparam int unsigned ICNT_BIT = 32;

  // overflow decision for one counter in one cycle
  function automatic logic wrap_hit(input logic inc, input logic c32,
                                    input logic c64, input logic long_mode);
    return inc & (long_mode ? c64 : c32);
  endfunction

  // positions that hold a real flag
  function automatic logic [FLAG_W-1:0] impl_mask(input int unsigned n_evt,
                                                  input bit has_icnt);
    logic [FLAG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_EVT; i++) begin
      if (i < n_evt) m[i] = 1'b1;
    end
    m[CYC_BIT]  = 1'b1;
    m[ICNT_BIT] = has_icnt;
    return m;
  endfunction

  // hardware and set-view sources win over the clear view
  function automatic logic [FLAG_W-1:0] next_flags(input logic [FLAG_W-1:0] q,
                                                   input logic [FLAG_W-1:0] hw,
                                                   input logic [FLAG_W-1:0] sset,
                                                   input logic [FLAG_W-1:0] sclr,
                                                   input logic [FLAG_W-1:0] mask);
    return ((q & ~sclr) | sset | hw) & mask;
  endfunction
endpackage

// File: rtl/ovf_wrap_detect.sv
module ovf_wrap_detect (
  input  logic inc,
  input  logic c32,
  input  logic c64,
  input  logic long_mode,
  output logic hit
);
  assign hit = ovf_pkg::wrap_hit(inc, c32, c64, long_mode);
endmodule

// File: rtl/ovf_flag_bank.sv
module ovf_flag_bank #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  assign d = ovf_pkg::next_flags(q, hw_set, sw_set, sw_clr, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ovf_irq_reduce.sv
module ovf_irq_reduce #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  output logic         any
);
  assign any = |(flags & en);
endmodule

// File: rtl/ovf_status_unit.sv
module ovf_status_unit #(
  parameter int unsigned NUM_EVT  = 6,
  parameter bit          HAS_ICNT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_inc,
  input  logic               cyc_c32,
  input  logic               cyc_c64,
  input  logic               cyc_long,
  input  logic               icnt_inc,
  input  logic               icnt_c32,
  input  logic               icnt_c64,
  input  logic [NUM_EVT-1:0] evt_inc,
  input  logic [NUM_EVT-1:0] evt_c32,
  input  logic [NUM_EVT-1:0] evt_c64,
  input  logic               evt_long_hyp,
  input  logic               evt_long_loc,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [63:0]        wdata,
  input  logic [63:0]        irq_en,
  output logic [63:0]        rd_data,
  output logic               ovf_any
);
  import ovf_pkg::*;

  localparam logic [FLAG_W-1:0] IMPL_MASK = impl_mask(NUM_EVT, HAS_ICNT);

  // named internal events, observed by the checker
  logic              evt_long;
  logic [FLAG_W-1:0] raw_hit;
  logic [FLAG_W-1:0] hw_hit;
  logic [FLAG_W-1:0] sw_set;
  logic [FLAG_W-1:0] sw_clr;
  logic [FLAG_W-1:0] flags;

  assign evt_long = evt_long_hyp | evt_long_loc;

  for (genvar i = 0; i < MAX_EVT; i++) begin : g_evt
    if (i < NUM_EVT) begin : g_on
      ovf_wrap_detect u_det (
        .inc(evt_inc[i]), .c32(evt_c32[i]), .c64(evt_c64[i]),
        .long_mode(evt_long), .hit(raw_hit[i])
      );
    end else begin : g_off
      assign raw_hit[i] = 1'b0;
    end
  end

  ovf_wrap_detect u_cyc (
    .inc(cyc_inc), .c32(cyc_c32), .c64(cyc_c64),
    .long_mode(cyc_long), .hit(raw_hit[CYC_BIT])
  );

  ovf_wrap_detect u_icnt (
    .inc(icnt_inc), .c32(icnt_c32), .c64(icnt_c64),
    .long_mode(evt_long), .hit(raw_hit[ICNT_BIT])
  );

  assign raw_hit[FLAG_W-1:ICNT_BIT+1] = '0;

  assign hw_hit = raw_hit & IMPL_MASK;
  assign sw_set = set_we ? (wdata & IMPL_MASK) : '0;
  assign sw_clr = clr_we ? (wdata & IMPL_MASK) : '0;

  ovf_flag_bank #(.W(FLAG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_hit), .sw_set(sw_set),
    .sw_clr(sw_clr), .mask(IMPL_MASK), .q(flags)
  );

  ovf_irq_reduce #(.W(FLAG_W)) u_irq (
    .flags(flags), .en(irq_en), .any(ovf_any)
  );

  assign rd_data = flags;
endmodule

// File: rtl/ovf_status_chk.sv
module ovf_status_chk #(
  parameter int unsigned NUM_EVT  = 6,
  parameter bit          HAS_ICNT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] hw_hit,
  input logic [63:0] sw_set,
  input logic [63:0] sw_clr,
  input logic [63:0] irq_en,
  input logic [63:0] rd_data,
  input logic        ovf_any
);
  localparam logic [63:0] LIVE = ovf_pkg::impl_mask(NUM_EVT, HAS_ICNT);

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:33] == '0); // R6
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == '0); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ~$past(rd_data) & ~$past(hw_hit | sw_set)) == '0)); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rd_data) & ~$past(sw_clr)) & ~rd_data) == '0)); // R7
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & $past(sw_clr & ~sw_set & ~hw_hit)) == '0)); // R8
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & $past(hw_hit)) == $past(hw_hit))); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & $past(sw_set)) == $past(sw_set))); // R10
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_any == |(rd_data & irq_en)); // R11
endmodule

bind ovf_status_unit ovf_status_chk #(.NUM_EVT(NUM_EVT), .HAS_ICNT(HAS_ICNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_hit(hw_hit), .sw_set(sw_set), .sw_clr(sw_clr),
  .irq_en(irq_en), .rd_data(rd_data), .ovf_any(ovf_any)
);

// File: tb/tb_ovf_status_unit.sv
`timescale 1ns/1ps
module tb_ovf_status_unit;
  localparam int unsigned NE = 6;
  localparam logic [63:0] TB_MASK = 64'h0000_0001_8000_003F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_inc, cyc_c32, cyc_c64, cyc_long;
  logic          icnt_inc, icnt_c32, icnt_c64;
  logic [NE-1:0] evt_inc, evt_c32, evt_c64;
  logic          evt_long_hyp, evt_long_loc;
  logic          set_we, clr_we;
  logic [63:0]   wdata, irq_en, rd_data;
  logic          ovf_any;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [63:0] exp_q = '0;

  always #2 clk = ~clk;

  ovf_status_unit #(.NUM_EVT(NE), .HAS_ICNT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_inc(cyc_inc), .cyc_c32(cyc_c32), .cyc_c64(cyc_c64),
    .cyc_long(cyc_long), .icnt_inc(icnt_inc), .icnt_c32(icnt_c32), .icnt_c64(icnt_c64),
    .evt_inc(evt_inc), .evt_c32(evt_c32), .evt_c64(evt_c64),
    .evt_long_hyp(evt_long_hyp), .evt_long_loc(evt_long_loc),
    .set_we(set_we), .clr_we(clr_we), .wdata(wdata), .irq_en(irq_en),
    .rd_data(rd_data), .ovf_any(ovf_any)
  );

  // bench view of the overflow events this cycle
  function automatic logic [63:0] model_hw();
    logic [63:0] v = '0;
    logic lng = evt_long_hyp || evt_long_loc;
    for (int n = 0; n < NE; n++)
      if (evt_inc[n] && (lng ? evt_c64[n] : evt_c32[n])) v[n] = 1'b1;
    if (cyc_inc && (cyc_long ? cyc_c64 : cyc_c32)) v[31] = 1'b1;
    if (icnt_inc && (lng ? icnt_c64 : icnt_c32)) v[32] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] model_next(input logic [63:0] cur);
    logic [63:0] r = cur;
    if (clr_we) r = r & ~wdata;
    if (set_we) r = r | wdata;
    r = r | model_hw();
    return r & TB_MASK;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    cyc_inc = 0; cyc_c32 = 0; cyc_c64 = 0;
    icnt_inc = 0; icnt_c32 = 0; icnt_c64 = 0;
    evt_inc = '0; evt_c32 = '0; evt_c64 = '0;
    set_we = 0; clr_we = 0; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    exp_q = model_next(exp_q);
    @(negedge clk);
  endtask

  task automatic step_chk(input string tag);
    tick();
    check(tag, rd_data, exp_q);
    check({tag, " any"}, {63'b0, ovf_any}, {63'b0, |(exp_q & irq_en)});
    idle();
  endtask

  task automatic wipe();
    clr_we = 1; wdata = '1;
    tick();
    idle();
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    idle();
    cyc_long = 0; evt_long_hyp = 0; evt_long_loc = 0; irq_en = '0;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1;
    exp_q = '0;
    check("R1 reset word", rd_data, 64'h0);
    check("R1 reset any", {63'b0, ovf_any}, 64'h0);

    // R2 cycle counter mode
    cyc_c32 = 1; cyc_c64 = 1; step_chk("R2 carry w/o inc");
    cyc_inc = 1; cyc_c32 = 1; step_chk("R2 short wrap");
    check("R2 bit31", {63'b0, rd_data[31]}, 64'h1);
    wipe();
    cyc_long = 1; cyc_inc = 1; cyc_c32 = 1; step_chk("R2 long ignores c32");
    cyc_inc = 1; cyc_c64 = 1; step_chk("R2 long wrap");
    cyc_long = 0; wipe();

    // R3 event mode formed by OR
    evt_inc[2] = 1; evt_c32[2] = 1; step_chk("R3 evt short");
    wipe();
    evt_long_hyp = 1; evt_inc[2] = 1; evt_c32[2] = 1; step_chk("R3 hyp long ignores c32");
    evt_long_hyp = 0; evt_long_loc = 1; evt_inc[4] = 1; evt_c32[4] = 1; step_chk("R3 loc long ignores c32");
    evt_inc[4] = 1; evt_c64[4] = 1; step_chk("R3 loc long wrap");
    evt_long_loc = 0; wipe();

    // R5 instruction counter
    icnt_inc = 1; icnt_c32 = 1; step_chk("R5 icnt wrap");
    check("R5 bit32", {63'b0, rd_data[32]}, 64'h1);
    wipe();

    // R4 / R6 masking
    set_we = 1; wdata = '1; step_chk("R4 set all");
    check("R6 high bits", {31'b0, rd_data[63:33]}, 64'h0);
    check("R4 readable mask", rd_data, TB_MASK);
    clr_we = 1; wdata = '1; step_chk("R8 clear all");

    // R7 sticky, R8 zero writes
    set_we = 1; wdata = 64'h0000_0000_8000_0005; step_chk("R8 set view");
    repeat (5) tick();
    check("R7 held", rd_data, 64'h0000_0000_8000_0005);
    clr_we = 1; wdata = 64'h0; step_chk("R8 zero clear no effect");
    clr_we = 1; wdata = 64'h1; step_chk("R8 clear one bit");

    // R9 overflow beats clear
    cyc_inc = 1; cyc_c32 = 1; clr_we = 1; wdata = 64'h0000_0000_8000_0000;
    step_chk("R9 cyc collision");
    check("R9 bit31 kept", {63'b0, rd_data[31]}, 64'h1);
    evt_inc[0] = 1; evt_c32[0] = 1; clr_we = 1; wdata = 64'h1; step_chk("R9 evt collision");

    // R10 set beats clear
    set_we = 1; clr_we = 1; wdata = 64'h0000_0000_0000_0008; step_chk("R10 set+clear");
    check("R10 bit3", {63'b0, rd_data[3]}, 64'h1);

    // R11 summary output
    wipe();
    set_we = 1; wdata = 64'h8; irq_en = 64'h0; step_chk("R11 disabled");
    irq_en = 64'h8; tick(); check("R11 enabled", {63'b0, ovf_any}, 64'h1);
    irq_en = 64'h0000_0000_0000_0040; set_we = 1; wdata = 64'h40; step_chk("R11 unimpl bit");
    check("R11 unimpl any", {63'b0, ovf_any}, 64'h0);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      evt_inc = NE'($urandom); evt_c32 = NE'($urandom); evt_c64 = NE'($urandom);
      cyc_inc = ($urandom % 4) == 0; cyc_c32 = $urandom; cyc_c64 = $urandom;
      icnt_inc = ($urandom % 4) == 0; icnt_c32 = $urandom; icnt_c64 = $urandom;
      if ((k % 16) == 0) begin
        cyc_long = $urandom; evt_long_hyp = $urandom; evt_long_loc = $urandom;
        irq_en = {$urandom, $urandom};
      end
      set_we = ($urandom % 8) == 0; clr_we = ($urandom % 3) == 0;
      wdata = {$urandom, $urandom};
      step_chk("R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule